// File: doc/BRIEF.md
# DDR2 Mode-Register Start-Up Sequencer

After reset, this block brings an attached DDR2 SDRAM into a known operating mode. It drives the clock-enable and command strobes, the bank-address bus and the address bus. The command sequence is as follows:

- a precharge of every bank;
- the extended mode register writes;
- the main mode register write;
- a closing precharge of every bank.

When the sequence ends, the block raises a completion flag. From then on the normal command scheduler owns the command bus. Mode registers are only ever written here, during start-up.

The programmed mode is fixed at:

- burst length 8;
- sequential burst order;
- additive latency zero;
- delay-locked loop enabled;
- termination off.

The CAS latency comes from a configuration input and is clamped to the supported range. A bank-count code selects the short or the long extended-register sequence. A programmable count of idle (NOP) cycles separates every pair of commands. These cycle counts model the waiting times the memory needs.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low, `ddr_cke` is 0, `ddr_cs_n` is 1 and `init_done` is 0. At the first rising edge that samples `rst_n` high, `ddr_cke` goes to 1 and the bus carries NOP. `ddr_cke` is 1 whenever `ddr_cs_n` is 0.
- R2: Command encodings on {cs_n, ras_n, cas_n, we_n} are:
  - NOP = 0111;
  - precharge-all = 0010, with address bit 10 at 1 and every other address and bank bit at 0;
  - mode write = 0000.
- R3: For bank code 0, 1 or 2 (1, 2 or 4 banks), the issued commands are, in order:
  - precharge-all;
  - extended register 1 write (bank address 1);
  - main mode write (bank address 0);
  - precharge-all.
- R4: For bank code 3 (8 banks), the issued commands are, in order:
  - precharge-all;
  - extended register 2 write (bank address 2);
  - extended register 3 write (bank address 3);
  - extended register 1 write (bank address 1);
  - main mode write (bank address 0);
  - precharge-all.
- R5: The main mode word has these fields, with all other address bits 0:
  - address[2:0] = 011 (burst of 8);
  - address[3] = 0 (sequential);
  - address[6:4] = the CAS latency;
  - address[11:9] = write-recovery cycles minus one (2 for the default of 3 cycles).
- R6: A `cfg_cas_lat` value of 2, 3, 4 or 5 is written unchanged into address[6:4]; any other value is written as 5.
- R7: Every extended register write carries an all-zero address word. This leaves the delay-locked loop on, additive latency at 0 and termination off.
- R8: Exactly G NOP cycles precede each command, where G is `cfg_gap`, and a value of 0 is treated as 1. The first G NOP cycles begin at the cycle where `ddr_cke` first reads 1.
- R9: `init_done` rises in the cycle right after the final precharge-all and stays 1 until reset. From then on the bus carries only NOP, so no mode write ever follows `init_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_cas_lat | input | 3 | Requested CAS latency |
| cfg_bank_code | input | 2 | Device bank count code: 0=1, 1=2, 2=4, 3=8 banks |
| cfg_gap | input | GAP_W (4) | Minimum NOP cycles before each command |
| ddr_cke | output | 1 | Clock enable to the memory |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W (3) | Bank address |
| ddr_addr | output | ADDR_W (14) | Address bus |
| init_done | output | 1 | Start-up complete; scheduler may issue commands |

## Verification
Six configurations are run:

- Bank codes 1 and 2 (short sequence) are run against code 3 (long sequence). This tells the two extended-register orderings apart and catches a remap that skips or repeats a slot.
- CAS latencies 2 through 5 check that the field is placed in bits 6:4 unchanged. The values 0 and 7 show that out-of-range requests are clamped rather than truncated or passed through.
- Gap values 0, 1, 3, 4 and 5 separate the zero-as-one rule from an off-by-one error in the NOP counter.
- After completion, the bus is watched for several idle cycles. This catches a sequencer that keeps issuing commands or drops its completion flag.

// File: rtl/ddr2_init_pkg.sv
// Shared types and helpers for the DDR2 start-up sequencer.
// Assumes a 3-bit CAS latency request and a fixed six-slot command plan.
package ddr2_init_pkg;

    // Abstract command kinds produced by the sequencer.
    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_NOP   = 2'd1,
        CMD_PREA  = 2'd2,
        CMD_MODE  = 2'd3
    } cmd_kind_e;

    // Controller phases.
    typedef enum logic [1:0] {
        PH_RESET = 2'd0,
        PH_GAP   = 2'd1,
        PH_CMD   = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    // Active-low command strobes.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam int unsigned SLOT_W = 3;

    // Slot plan of the long sequence; the short sequence skips slots 1 and 2.
    localparam logic [SLOT_W-1:0] SLOT_PREA_FIRST = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_EXT2       = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_EXT3       = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_EXT1       = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_MAIN       = 3'd4;
    localparam logic [SLOT_W-1:0] SLOT_PREA_LAST  = 3'd5;

    // Maps a CAS latency request onto the supported set, defaulting to 5.
    function automatic logic [2:0] clamp_cas(input logic [2:0] raw);
        if (raw >= 3'd2 && raw <= 3'd5) begin
            return raw;
        end
        return 3'd5;
    endfunction

endpackage

// File: rtl/ddr2_init_pin_enc.sv
// Translates an abstract command kind into the four active-low strobes.
// Assumes the caller drives CKE separately.
module ddr2_init_pin_enc
    import ddr2_init_pkg::*;
(
    input  cmd_kind_e kind,
    output cmd_pins_t pins
);

    // Strobe truth table.
    always_comb begin
        unique case (kind)
            CMD_DESEL: pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_NOP:   pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_PREA:  pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_MODE:  pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:   pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end

endmodule

// File: rtl/ddr2_init_word_gen.sv
// Builds the command kind, bank address and address word for one plan slot.
// Assumes ADDR_W >= 13 and BA_W >= 2; the result is purely combinational.
module ddr2_init_word_gen
    import ddr2_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned BA_W   = 3,
    parameter int unsigned WR_CYC = 3
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [2:0]        cas_raw,
    output cmd_kind_e         kind,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [2:0] WR_CODE = 3'(WR_CYC - 1);

    logic [2:0] cas_eff;
    assign cas_eff = clamp_cas(cas_raw);

    // Slot to command/word mapping.
    always_comb begin
        kind = CMD_MODE;
        ba   = '0;
        addr = '0;
        unique case (slot)
            SLOT_PREA_FIRST, SLOT_PREA_LAST: begin
                kind     = CMD_PREA;
                addr[10] = 1'b1;
            end
            SLOT_EXT2: ba = BA_W'(2);
            SLOT_EXT3: ba = BA_W'(3);
            SLOT_EXT1: ba = BA_W'(1);
            SLOT_MAIN: begin
                addr[2:0]  = 3'b011;
                addr[3]    = 1'b0;
                addr[6:4]  = cas_eff;
                addr[11:9] = WR_CODE;
            end
            default: kind = CMD_NOP;
        endcase
    end

    // Main mode word never carries an unsupported latency (R6).
    always_comb begin
        if (slot == SLOT_MAIN) begin
            assert_cas_supported_R6: assert (addr[6:4] >= 3'd2 && addr[6:4] <= 3'd5);
        end
    end

endmodule

// File: rtl/ddr2_init_gap_timer.sv
// Down-counter for the NOP spacing between commands.
// Assumes load values are non-zero; 'last' marks the final NOP cycle.
module ddr2_init_gap_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);

    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == W'(1));

    // A zero load would stall the sequence (R8).
    assert_load_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

    // Counting only happens on a live count (R8).
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 start-up sequencer: precharge-all, extended mode writes, main mode
// write, precharge-all, then completion. Assumes configuration inputs are
// stable from reset release until init_done.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned BA_W   = 3,
    parameter int unsigned GAP_W  = 4,
    parameter int unsigned WR_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [1:0]        cfg_bank_code,
    input  logic [GAP_W-1:0]  cfg_gap,
    output logic              ddr_cke,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [BA_W-1:0]   ddr_ba,
    output logic [ADDR_W-1:0] ddr_addr,
    output logic              init_done
);

    localparam logic [SLOT_W-1:0] SHORT_SKIP = 3'd2;

    phase_e            phase_q, phase_d;
    logic [SLOT_W-1:0] step_q, step_d;
    logic [SLOT_W-1:0] slot;
    logic              eight_banks;
    logic [GAP_W-1:0]  gap_eff;
    logic              tmr_load, tmr_dec, tmr_last;
    cmd_kind_e         word_kind, out_kind;
    logic [BA_W-1:0]   word_ba;
    logic [ADDR_W-1:0] word_addr;
    cmd_pins_t         pins;

    assign eight_banks = (cfg_bank_code == 2'b11);
    assign gap_eff     = (cfg_gap == '0) ? GAP_W'(1) : cfg_gap;

    // Short plan skips the two high extended registers.
    assign slot = (!eight_banks && step_q != '0) ? step_q + SHORT_SKIP : step_q;

    ddr2_init_word_gen #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .WR_CYC (WR_CYC)
    ) word_i (
        .slot    (slot),
        .cas_raw (cfg_cas_lat),
        .kind    (word_kind),
        .ba      (word_ba),
        .addr    (word_addr)
    );

    ddr2_init_gap_timer #(
        .W (GAP_W)
    ) gap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (gap_eff),
        .dec      (tmr_dec),
        .last     (tmr_last)
    );

    // Next-phase and timer control.
    always_comb begin
        phase_d  = phase_q;
        step_d   = step_q;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        unique case (phase_q)
            PH_RESET: begin
                phase_d  = PH_GAP;
                tmr_load = 1'b1;
            end
            PH_GAP: begin
                tmr_dec = 1'b1;
                if (tmr_last) phase_d = PH_CMD;
            end
            PH_CMD: begin
                if (slot == SLOT_PREA_LAST) begin
                    phase_d = PH_DONE;
                end else begin
                    step_d   = step_q + 1'b1;
                    phase_d  = PH_GAP;
                    tmr_load = 1'b1;
                end
            end
            default: phase_d = PH_DONE;
        endcase
    end

    // Phase and step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RESET;
            step_q  <= '0;
        end else begin
            phase_q <= phase_d;
            step_q  <= step_d;
        end
    end

    // Command selection for the bus.
    always_comb begin
        unique case (phase_q)
            PH_RESET: out_kind = CMD_DESEL;
            PH_CMD:   out_kind = word_kind;
            default:  out_kind = CMD_NOP;
        endcase
    end

    ddr2_init_pin_enc enc_i (
        .kind (out_kind),
        .pins (pins)
    );

    // Output drive.
    assign ddr_cke   = (phase_q != PH_RESET);
    assign ddr_cs_n  = pins.cs_n;
    assign ddr_ras_n = pins.ras_n;
    assign ddr_cas_n = pins.cas_n;
    assign ddr_we_n  = pins.we_n;
    assign ddr_ba    = (phase_q == PH_CMD) ? word_ba : '0;
    assign ddr_addr  = (phase_q == PH_CMD) ? word_addr : '0;
    assign init_done = (phase_q == PH_DONE);

    // Selected device always has its clock enabled (R1).
    assert_cke_with_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ddr_cs_n |-> ddr_cke);

    // Precharge-all carries address bit 10 high (R2).
    assert_prea_a10_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr_cs_n && !ddr_ras_n && ddr_cas_n && !ddr_we_n) |-> ddr_addr[10]);

    // Every command follows at least one NOP cycle (R8).
    assert_cmd_after_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CMD) |-> ($past(phase_q) == PH_GAP));

    // Completion follows the final precharge-all (R9).
    assert_done_after_prea_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ($past(!ddr_cs_n && !ddr_ras_n && ddr_cas_n && !ddr_we_n)));

    // Completion is sticky (R9).
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // No mode write once complete (R9).
    assert_no_mode_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !(!ddr_cs_n && !ddr_ras_n && !ddr_cas_n && !ddr_we_n));

endmodule

// File: tb/ddr2_init_seq_tb_top.sv
// Scoreboard bench: the driver queues the expected command list, the monitor
// decodes the bus each cycle and compares commands, gaps and completion.
module ddr2_init_seq_tb_top;

    typedef struct {
        bit          is_mode;
        logic [2:0]  ba;
        logic [13:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_cas_lat = 3'd3;
    logic [1:0]  cfg_bank_code = 2'd0;
    logic [3:0]  cfg_gap = 4'd1;
    logic        ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [2:0]  ddr_ba;
    logic [13:0] ddr_addr;
    logic        init_done;

    int   n_checks = 0;
    int   n_fails = 0;
    int   cycles = 0;
    bit   finished = 0;
    exp_t exp_q[$];
    bit   mon_on = 0;
    bit   first_flag = 0;
    bit   done_seen = 0;
    bit   prev_prea = 0;
    int   nop_run = 0;
    int   exp_gap = 1;
    string seq_tag = "R3";

    always #2 clk = ~clk;

    ddr2_init_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_cas_lat   (cfg_cas_lat),
        .cfg_bank_code (cfg_bank_code),
        .cfg_gap       (cfg_gap),
        .ddr_cke       (ddr_cke),
        .ddr_cs_n      (ddr_cs_n),
        .ddr_ras_n     (ddr_ras_n),
        .ddr_cas_n     (ddr_cas_n),
        .ddr_we_n      (ddr_we_n),
        .ddr_ba        (ddr_ba),
        .ddr_addr      (ddr_addr),
        .init_done     (init_done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    endtask

    // Monitor: decode the bus once per cycle, away from the clock edge.
    always @(posedge clk) begin
        #1;
        if (mon_on && rst_n) begin
            automatic bit is_nop  = !ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n;
            automatic bit is_prea = !ddr_cs_n && !ddr_ras_n && ddr_cas_n && !ddr_we_n;
            automatic bit is_mode = !ddr_cs_n && !ddr_ras_n && !ddr_cas_n && !ddr_we_n;
            automatic int pinv = {ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
            if (first_flag) begin
                chk(ddr_cke && is_nop, "R1", "CKE high with NOP after reset", pinv, 5'b10111);
                first_flag = 0;
            end
            if (done_seen) begin
                chk(init_done == 1'b1, "R9", "done stays high", init_done, 1);
                chk(is_nop, "R9", "bus idle after done", pinv, 5'b10111);
            end else if (init_done) begin
                chk(prev_prea, "R9", "done one cycle after final precharge", prev_prea, 1);
                chk(exp_q.size() == 0, seq_tag, "commands left at done", exp_q.size(), 0);
                chk(is_nop, "R9", "NOP when done rises", pinv, 5'b10111);
                done_seen = 1;
            end else if (is_nop) begin
                nop_run++;
            end else if (is_prea || is_mode) begin
                chk(ddr_cke, "R2", "CKE during command", ddr_cke, 1);
                chk(nop_run == exp_gap, "R8", "NOP gap before command", nop_run, exp_gap);
                if (exp_q.size() == 0) begin
                    chk(0, seq_tag, "unexpected extra command", pinv, 0);
                end else begin
                    automatic exp_t e = exp_q.pop_front();
                    chk(is_mode == e.is_mode, e.tag, "command kind (1=mode)", is_mode, e.is_mode);
                    chk(ddr_ba == e.ba, e.tag, "bank address", ddr_ba, e.ba);
                    chk(ddr_addr == e.addr, e.tag, "address word", ddr_addr, e.addr);
                end
                nop_run = 0;
            end else begin
                chk(0, "R2", "unknown command encoding", pinv, 5'b10111);
            end
            prev_prea = is_prea;
        end
    end

    function automatic exp_t mk(input bit m, input logic [2:0] ba,
                                input logic [13:0] addr, input string tag);
        exp_t e;
        e.is_mode = m;
        e.ba      = ba;
        e.addr    = addr;
        e.tag     = tag;
        return e;
    endfunction

    // Driver: apply reset and configuration, queue the expected sequence.
    task automatic run_case(input logic [2:0] cl, input logic [1:0] bank, input logic [3:0] gap);
        logic [13:0] mr;
        logic [2:0]  cl_exp;
        mon_on = 0;
        @(negedge clk);
        rst_n         = 1'b0;
        cfg_cas_lat   = cl;
        cfg_bank_code = bank;
        cfg_gap       = gap;
        repeat (3) @(negedge clk);
        chk(ddr_cke == 1'b0, "R1", "CKE low in reset", ddr_cke, 0);
        chk(ddr_cs_n == 1'b1, "R1", "deselect in reset", ddr_cs_n, 1);
        chk(init_done == 1'b0, "R1", "done low in reset", init_done, 0);
        seq_tag = (bank == 2'd3) ? "R4" : "R3";
        cl_exp  = (cl >= 3'd2 && cl <= 3'd5) ? cl : 3'd5;
        mr         = '0;
        mr[2:0]    = 3'b011;
        mr[6:4]    = cl_exp;
        mr[11:9]   = 3'd2;
        exp_q.delete();
        exp_q.push_back(mk(0, 3'd0, 14'h0400, seq_tag));
        if (bank == 2'd3) begin
            exp_q.push_back(mk(1, 3'd2, 14'h0000, "R4"));
            exp_q.push_back(mk(1, 3'd3, 14'h0000, "R4"));
        end
        exp_q.push_back(mk(1, 3'd1, 14'h0000, "R7"));
        exp_q.push_back(mk(1, 3'd0, mr, (cl == cl_exp) ? "R5" : "R6"));
        exp_q.push_back(mk(0, 3'd0, 14'h0400, "R2"));
        exp_gap    = (gap == 4'd0) ? 1 : int'(gap);
        first_flag = 1;
        done_seen  = 0;
        prev_prea  = 0;
        nop_run    = 0;
        mon_on     = 1;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 300 && !done_seen; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(done_seen, "R9", "done reached", done_seen, 1);
        mon_on = 0;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "R9", "watchdog expired", cycles, 0);
            summary();
        end
    end

    initial begin
        run_case(3'd3, 2'd2, 4'd2);
        run_case(3'd5, 2'd3, 4'd1);
        run_case(3'd7, 2'd3, 4'd0);
        run_case(3'd0, 2'd0, 4'd4);
        run_case(3'd2, 2'd1, 4'd3);
        run_case(3'd4, 2'd3, 4'd5);
        summary();
    end

endmodule